// File: doc/BRIEF.md
# Dual-Rail Token-Pipelined Prefix Adder

This block adds two unsigned operands and a carry bit. Every value moves through it as a dual-rail token. Each logical bit is carried on a true rail and a false rail. A bit set to one raises only its true rail, a bit set to zero raises only its false rail, and an all-zero spacer marks the gap between two data words. The work is split across a chain of stages:

- An entry stage forms the bitwise generate and propagate terms, with the carry-in folded into bit 0.
- A run of Kogge-Stone prefix levels follows, with spans 1, 2, 4 and so on. Their number is log2 of the width.
- A final stage forms the sum bits and the carry-out.

For the default width of eight there are five stages. Each stage keeps one handshake controller that serves every bit of that stage. The controller behaves as a C-element. It loads a valid token when its input is a complete code and the stage below has gone empty. It clears back to empty when its input is all zero and the stage below holds data.

The producer and consumer use a four-phase protocol:

- The producer drives a valid token and waits for `in_ack` to go high. It then drives the spacer and waits for `in_ack` to go low.
- The consumer sees a complete code on the sum rails and raises `sum_ack`. It lowers `sum_ack` once the rails have gone back to zero.

The controllers are modelled as clocked state, one evaluation per rising edge. For each stage, a flag on `stage_pwr` stands in for the power switch of that stage.

Top module: `dr_prefix_adder`

## Requirements
- R1: With free room in the first stage, `in_ack` goes high after a complete valid input code is presented. In a complete code, each of `a`, `b` and `cin` has exactly one rail high per bit: the true rail for 1, the false rail for 0. `in_ack` goes low again after the all-zero spacer is presented.
- R2: A valid output token carries the 9-bit value a + b + cin on `sum_t`, with bit 8 as the carry-out. `sum_f` holds the bitwise complement of `sum_t`.
- R3: While `sum_ack` stays low, a valid output token stays on the sum rails unchanged.
- R4: After `sum_ack` goes high and the spacer has been presented at the input, both sum rail vectors return to all zero.
- R5: Two valid tokens never sit in adjacent stages. A token queued behind an unacknowledged output waits with the stage just above the output stage empty, so `stage_pwr` reads 5'b10111.
- R6: An incomplete input code is never accepted. An incomplete code has some bit with both rails low, or some bit with both rails high. While one is presented, `in_ack` and `stage_pwr` stay zero.
- R7: Bit k of `stage_pwr` is high exactly while stage k holds a valid token. Bit 0 is the entry stage and the top bit is the output stage.
- R8: While `rst_n` is low, `in_ack`, `stage_pwr` and both sum rail vectors are zero.
- R9: Take a token presented to an empty pipeline, with `sum_ack` low, before rising edge 1. It appears on the sum rails at rising edge 5 and not before. At edge 3, `stage_pwr` reads 5'b00111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the controller model |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_t | input | W | Operand A, true rails |
| a_f | input | W | Operand A, false rails |
| b_t | input | W | Operand B, true rails |
| b_f | input | W | Operand B, false rails |
| cin_t | input | 1 | Carry-in, true rail |
| cin_f | input | 1 | Carry-in, false rail |
| in_ack | output | 1 | Acknowledge to the producer (entry stage holds data) |
| sum_t | output | W+1 | Sum and carry-out, true rails |
| sum_f | output | W+1 | Sum and carry-out, false rails |
| sum_ack | input | 1 | Acknowledge from the consumer |
| stage_pwr | output | log2(W)+2 | Per-stage power-enable flags |

## Verification
The bench builds the block only at the default width of eight. This gives five stages and three prefix levels, so the span-4 level is the last one, and a carry from bit 0 must cross every level to reach the carry-out. At that size, a stalled consumer makes the full back-pressure pattern visible, and the stage-by-stage fill seen through the five power flags can be counted edge by edge. Operands that ripple a carry through all eight bits (all-ones plus carry-in, 0x7F plus one) exercise the longest prefix path.

// File: rtl/dr_adder_pkg.sv
package dr_adder_pkg;

   function automatic int prefix_levels(input int w);
      return $clog2(w);
   endfunction

   function automatic int stage_count(input int w);
      return $clog2(w) + 2;
   endfunction

   function automatic bit is_pow2(input int w);
      return (w >= 2) && ((w & (w - 1)) == 0);
   endfunction

endpackage

// File: rtl/dr_stage_ctrl.sv
module dr_stage_ctrl #(
   parameter int DIN  = 8,
   parameter int DOUT = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DIN-1:0]  in_t,
   input  logic [DIN-1:0]  in_f,
   input  logic [DOUT-1:0] fn_val,
   input  logic            ack_dn,
   output logic [DOUT-1:0] q_t,
   output logic [DOUT-1:0] q_f,
   output logic            full
);

   logic in_valid;
   logic in_empty;

   // completion detection: every bit has exactly one rail high, or all low
   assign in_valid = &(in_t ^ in_f);
   assign in_empty = ~|(in_t | in_f);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         q_t  <= '0;
         q_f  <= '0;
      end else if (!full && in_valid && !ack_dn) begin
         full <= 1'b1;
         q_t  <= fn_val;
         q_f  <= ~fn_val;
      end else if (full && in_empty && ack_dn) begin
         full <= 1'b0;
         q_t  <= '0;
         q_f  <= '0;
      end
   end

   AST_LOAD_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full) |-> &(q_t ^ q_f));                        // R2
   AST_DISCHARGE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(full) |-> ~|(q_t | q_f));                       // R4
   AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (full && $past(full)) |-> ($stable(q_t) && $stable(q_f))); // R3

endmodule

// File: rtl/dr_gp_logic.sv
module dr_gp_logic #(
   parameter int W = 8
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  logic           cin,
   output logic [3*W:0]   y
);

   logic [W-1:0] gen;
   logic [W-1:0] prp;
   logic [W-1:0] hx;

   always_comb begin
      hx  = a ^ b;
      gen = a & b;
      prp = hx;
      // carry-in folded into bit 0 so the prefix spans never need position -1
      gen[0] = (a[0] & b[0]) | (hx[0] & cin);
      prp[0] = 1'b0;
      y = {cin, hx, prp, gen};
   end

endmodule

// File: rtl/dr_prefix_logic.sv
module dr_prefix_logic #(
   parameter int W    = 8,
   parameter int SPAN = 1
) (
   input  logic [3*W:0] d,
   output logic [3*W:0] y
);

   logic [W-1:0] g_in, p_in, g_out, p_out;

   assign g_in = d[W-1:0];
   assign p_in = d[2*W-1:W];

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= SPAN) begin : g_merge
         assign g_out[i] = g_in[i] | (p_in[i] & g_in[i-SPAN]);
         assign p_out[i] = p_in[i] & p_in[i-SPAN];
      end else begin : g_pass
         assign g_out[i] = g_in[i];
         assign p_out[i] = p_in[i];
      end
   end

   assign y = {d[3*W:2*W], p_out, g_out};

endmodule

// File: rtl/dr_sum_logic.sv
module dr_sum_logic #(
   parameter int W = 8
) (
   input  logic [3*W:0] d,
   output logic [W:0]   s
);

   logic [W-1:0] grp_g, hx, carry;
   logic         sink_unused;

   assign grp_g = d[W-1:0];
   assign hx    = d[3*W-1:2*W];
   assign carry = {grp_g[W-2:0], d[3*W]};
   assign s     = {grp_g[W-1], hx ^ carry};
   assign sink_unused = ^d[2*W-1:W];

endmodule

// File: rtl/dr_prefix_adder.sv
module dr_prefix_adder #(
   parameter int W = 8
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [W-1:0]                           a_t,
   input  logic [W-1:0]                           a_f,
   input  logic [W-1:0]                           b_t,
   input  logic [W-1:0]                           b_f,
   input  logic                                   cin_t,
   input  logic                                   cin_f,
   output logic                                   in_ack,
   output logic [W:0]                             sum_t,
   output logic [W:0]                             sum_f,
   input  logic                                   sum_ack,
   output logic [dr_adder_pkg::stage_count(W)-1:0] stage_pwr
);

   localparam int NPFX = dr_adder_pkg::prefix_levels(W);
   localparam int NSTG = dr_adder_pkg::stage_count(W);
   localparam int DP   = 3 * W + 1;
   localparam int DI   = 2 * W + 1;

   initial begin
      assert (dr_adder_pkg::is_pow2(W))
         else $error("dr_prefix_adder: W must be a power of two, at least 2");
   end

   logic [NSTG-1:0] full;
   logic [DP-1:0]   pt [0:NPFX];
   logic [DP-1:0]   pf [0:NPFX];
   logic [DP-1:0]   gp_fn;
   logic [DI-1:0]   src_t, src_f;

   assign src_t = {cin_t, b_t, a_t};
   assign src_f = {cin_f, b_f, a_f};

   dr_gp_logic #(.W(W)) u_gp (
      .a(a_t), .b(b_t), .cin(cin_t), .y(gp_fn)
   );

   dr_stage_ctrl #(.DIN(DI), .DOUT(DP)) u_hc_gp (
      .clk(clk), .rst_n(rst_n), .in_t(src_t), .in_f(src_f),
      .fn_val(gp_fn), .ack_dn(full[1]),
      .q_t(pt[0]), .q_f(pf[0]), .full(full[0])
   );

   for (genvar k = 0; k < NPFX; k++) begin : g_lvl
      logic [DP-1:0] fn;

      dr_prefix_logic #(.W(W), .SPAN(1 << k)) u_pfx (
         .d(pt[k]), .y(fn)
      );

      dr_stage_ctrl #(.DIN(DP), .DOUT(DP)) u_hc (
         .clk(clk), .rst_n(rst_n), .in_t(pt[k]), .in_f(pf[k]),
         .fn_val(fn), .ack_dn(full[k+2]),
         .q_t(pt[k+1]), .q_f(pf[k+1]), .full(full[k+1])
      );
   end

   logic [W:0] sum_fn;

   dr_sum_logic #(.W(W)) u_sum (
      .d(pt[NPFX]), .s(sum_fn)
   );

   dr_stage_ctrl #(.DIN(DP), .DOUT(W+1)) u_hc_sum (
      .clk(clk), .rst_n(rst_n), .in_t(pt[NPFX]), .in_f(pf[NPFX]),
      .fn_val(sum_fn), .ack_dn(sum_ack),
      .q_t(sum_t), .q_f(sum_f), .full(full[NSTG-1])
   );

   assign in_ack    = full[0];
   assign stage_pwr = full;

   for (genvar k = 0; k < NSTG - 1; k++) begin : g_gap
      AST_SPACER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(full[k]) |-> !full[k+1]);                    // R5
   end

   AST_ACK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ack) |-> $past(&(src_t ^ src_f)));           // R6

endmodule

// File: tb/dr_prefix_adder_test.sv
`timescale 1ns/1ps
module dr_prefix_adder_test;

   localparam int W    = 8;
   localparam int NSTG = 5;
   localparam int NRND = 60;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic            rst_n = 1'b0;
   logic [W-1:0]    a_t = '0, a_f = '0, b_t = '0, b_f = '0;
   logic            cin_t = 1'b0, cin_f = 1'b0;
   logic            in_ack;
   logic [W:0]      sum_t, sum_f;
   logic            sum_ack = 1'b0;
   logic [NSTG-1:0] stage_pwr;
   logic            sum_ok, sum_nil;

   assign sum_ok  = &(sum_t ^ sum_f);
   assign sum_nil = ~|(sum_t | sum_f);

   dr_prefix_adder #(.W(W)) uut (
      .clk(clk), .rst_n(rst_n),
      .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
      .cin_t(cin_t), .cin_f(cin_f), .in_ack(in_ack),
      .sum_t(sum_t), .sum_f(sum_f), .sum_ack(sum_ack),
      .stage_pwr(stage_pwr)
   );

   int n_run  = 0;
   int n_fail = 0;

   // {a, b, cin, expected 9-bit sum}
   localparam logic [25:0] VEC [10] = '{
      {8'h00, 8'h00, 1'b0, 9'h000},
      {8'h00, 8'h00, 1'b1, 9'h001},
      {8'hFF, 8'h01, 1'b0, 9'h100},
      {8'hFF, 8'hFF, 1'b1, 9'h1FF},
      {8'h80, 8'h80, 1'b0, 9'h100},
      {8'h55, 8'hAA, 1'b1, 9'h100},
      {8'h12, 8'h34, 1'b0, 9'h046},
      {8'h7F, 8'h01, 1'b0, 9'h080},
      {8'h0F, 8'hF0, 1'b1, 9'h100},
      {8'hC8, 8'h64, 1'b0, 9'h12C}
   };

   logic [W-1:0] ra [NRND];
   logic [W-1:0] rb [NRND];
   logic         rc [NRND];

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic drive_token(input logic [W-1:0] a, input logic [W-1:0] b,
                              input logic c);
      a_t = a; a_f = ~a; b_t = b; b_f = ~b; cin_t = c; cin_f = ~c;
   endtask

   task automatic drive_spacer();
      a_t = '0; a_f = '0; b_t = '0; b_f = '0; cin_t = 1'b0; cin_f = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // serial transaction for table vectors: R1, R2, R4
   task automatic run_vec(input logic [25:0] v);
      logic [8:0] exp;
      exp = v[8:0];
      drive_token(v[25:18], v[17:10], v[9]);
      while (!in_ack) @(negedge clk);
      check(in_ack == 1'b1, "R1 in_ack high", 32'(in_ack), 32'd1);
      while (!sum_ok) @(negedge clk);
      check(sum_t == exp, "R2 sum true rails", 32'(sum_t), 32'(exp));
      check(sum_f == ~exp, "R2 sum false rails", 32'(sum_f), 32'(~exp));
      idle($urandom_range(0, 2));
      sum_ack = 1'b1;
      drive_spacer();
      while (!sum_nil) @(negedge clk);
      check((sum_t | sum_f) == '0, "R4 output spacer", 32'(sum_t | sum_f), 32'd0);
      sum_ack = 1'b0;
      while (in_ack) @(negedge clk);
      check(in_ack == 1'b0, "R1 in_ack low", 32'(in_ack), 32'd0);
      idle($urandom_range(0, 2));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      // R8: reset state
      idle(3);
      check(in_ack == 1'b0, "R8 in_ack", 32'(in_ack), 32'd0);
      check(stage_pwr == '0, "R8 stage_pwr", 32'(stage_pwr), 32'd0);
      check(sum_t == '0 && sum_f == '0, "R8 sum rails", 32'(sum_t | sum_f), 32'd0);
      rst_n = 1'b1;
      idle(2);

      // table of vectors
      for (int i = 0; i < 10; i++) run_vec(VEC[i]);

      // R9 + R7: latency and fill pattern into an empty pipeline
      drive_token(8'h03, 8'h04, 1'b0);
      idle(3);
      check(stage_pwr == 5'b00111, "R7 fill after edge 3", 32'(stage_pwr), 32'h07);
      idle(1);
      check(sum_nil == 1'b1, "R9 empty at edge 4", 32'(sum_t), 32'd0);
      idle(1);
      check(sum_ok && sum_t == 9'h007, "R9 valid at edge 5", 32'(sum_t), 32'h007);
      check(stage_pwr == 5'b11111, "R7 all stages hold", 32'(stage_pwr), 32'h1F);
      sum_ack = 1'b1;
      drive_spacer();
      while (!sum_nil || in_ack) @(negedge clk);
      idle(3);
      check(stage_pwr == '0, "R7 all stages drained", 32'(stage_pwr), 32'd0);
      sum_ack = 1'b0;
      idle(2);

      // R6: incomplete code (b rails all low)
      a_t = 8'hFF; a_f = 8'h00; b_t = '0; b_f = '0; cin_t = 1'b0; cin_f = 1'b1;
      idle(10);
      check(in_ack == 1'b0, "R6 partial code ack", 32'(in_ack), 32'd0);
      check(stage_pwr == '0, "R6 partial code pwr", 32'(stage_pwr), 32'd0);
      // R6: illegal code (both rails of a bit high)
      drive_token(8'h21, 8'h10, 1'b0);
      a_f[0] = 1'b1;
      idle(10);
      check(in_ack == 1'b0, "R6 illegal code ack", 32'(in_ack), 32'd0);
      check(sum_nil == 1'b1, "R6 illegal code output", 32'(sum_t), 32'd0);
      drive_spacer();
      idle(3);

      // R5 + R3: back-pressure with sum_ack held low
      drive_token(8'h40, 8'h22, 1'b1);
      while (!in_ack) @(negedge clk);
      drive_spacer();
      while (in_ack) @(negedge clk);
      drive_token(8'h9A, 8'h11, 1'b0);
      idle(15);
      check(sum_t == 9'h063, "R3 output held", 32'(sum_t), 32'h063);
      check(stage_pwr == 5'b10111, "R5 spacer gap pattern", 32'(stage_pwr), 32'h17);
      check(in_ack == 1'b1, "R5 queued token acked", 32'(in_ack), 32'd1);
      sum_ack = 1'b1;
      while (!sum_nil) @(negedge clk);
      sum_ack = 1'b0;
      while (!sum_ok) @(negedge clk);
      check(sum_t == 9'h0AB, "R5 queued token result", 32'(sum_t), 32'h0AB);
      sum_ack = 1'b1;
      drive_spacer();
      while (!sum_nil || in_ack) @(negedge clk);
      sum_ack = 1'b0;
      idle(3);

      // random stream with random handshake delays
      for (int j = 0; j < NRND; j++) begin
         ra[j] = W'($urandom_range(0, 255));
         rb[j] = W'($urandom_range(0, 255));
         rc[j] = 1'($urandom_range(0, 1));
      end
      fork
         begin : sender
            for (int j = 0; j < NRND; j++) begin
               drive_token(ra[j], rb[j], rc[j]);
               while (!in_ack) @(negedge clk);
               idle($urandom_range(0, 3));
               drive_spacer();
               while (in_ack) @(negedge clk);
               idle($urandom_range(0, 3));
            end
         end
         begin : receiver
            for (int j = 0; j < NRND; j++) begin
               logic [8:0] exp;
               exp = 9'(ra[j]) + 9'(rb[j]) + 9'(rc[j]);
               while (!sum_ok) @(negedge clk);
               check(sum_t == exp, "R2 random stream", 32'(sum_t), 32'(exp));
               idle($urandom_range(0, 4));
               sum_ack = 1'b1;
               while (!sum_nil) @(negedge clk);
               idle($urandom_range(0, 3));
               sum_ack = 1'b0;
            end
         end
      join
      idle(5);
      check(stage_pwr == '0, "R7 idle after stream", 32'(stage_pwr), 32'd0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule